// File: doc/BRIEF.md
# Four-Level Address Translation Walker

This block turns a 48-bit linear address into a physical page frame number. It uses a four-level hierarchy of page tables that lives in memory. Four small caches sit next to it. The deepest is a translation cache keyed by the whole page number. The other three hold table pointers, one for each upper level, and each is keyed by a longer address prefix than the one above it.

A request is accepted only while the walker is idle, and only one translation is handled at a time. The walker looks in all four caches at once and takes the deepest hit. It then reads from memory only the levels still missing, and each good entry it reads is written into the cache for its level. When nothing hits, the walk begins at the root table frame.

Each table read is one request on a memory port that waits for a response. An entry whose present bit is clear stops the walk with a fault. A flush input empties every cache.

Top module: `page_walker`

## Requirements
- R1: Level L (0 = root) takes its 9-bit index from these linear address bits: 47:39, 38:30, 29:21 and 20:12. The read address is the table frame shifted left by 12, plus the index times 8. The address stays stable until a response arrives.
- R2: With all caches empty, a translation makes exactly four reads, starting from the root frame. `pfn_o` is bits 47:12 of the last entry read. Each entry uses bit 0 as its present flag and bits 47:12 as the next frame.
- R3: A second translation of the same page (same bits 47:12) makes no memory read and returns the same frame.
- R4: A hit in the third-level pointer cache (tag: bits 47:21) resumes the walk at the last level, so it makes one read.
- R5: A hit in the second-level pointer cache (tag: bits 47:30) makes two reads.
- R6: A hit in only the top-level pointer cache (tag: bits 47:39) makes three reads.
- R7: When several caches hit, the deepest one is used.
- R8: An entry with bit 0 clear ends the walk with a single-cycle `fault_o` and `pfn_o` = 0. It fills no cache, so repeating the request performs the same read again.
- R9: A root entry that points back to the root table is used as a pointer at every level and fills every cache with the root frame.
- R10: Two top-level entries that point to the same table create separate second-level and third-level cache entries, one under each tag.
- R11: A flush pulse invalidates all entries in all caches.
- R12: Each cache has 4 entries and replaces them in round-robin order. A fifth new tag evicts the oldest fill.
- R13: `req_ready_o` is high only while idle. `done_o` is a one-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all cache entries |
| root_frame_i | input | 36 | Frame of the root table |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | 48 | Linear address to translate |
| mem_req_o | output | 1 | Table read pending |
| mem_addr_o | output | 48 | Physical address of the table entry |
| mem_rsp_valid_i | input | 1 | Read data valid, completes the read |
| mem_rsp_data_i | input | 64 | Table entry read |
| done_o | output | 1 | Translation finished (one cycle) |
| pfn_o | output | 36 | Resulting page frame number |
| fault_o | output | 1 | Walk hit a non-present entry (with done_o) |

## Verification
The main sweep flushes the caches and then walks sixteen addresses from the root. The top index and the last index are varied, and the memory latency changes from one walk to the next. This shows whether the index bits of each level reach the right read address.

Directed sequences then change one index field at a time against a warm cache. Each of these must read exactly as many levels as lie below the changed field, which separates the four cache depths and shows that the deepest hit wins.

Three table patterns are also tried: a root entry that points to itself, two root entries that share one table, and a non-present entry. These separate correct tag-keyed fills from fills keyed by table address, and from fills written on a faulting walk. A run of five pages through one cache checks the eviction order.

// File: rtl/pw_pkg.sv
package pw_pkg;
  parameter int unsigned VA_W  = 48;
  parameter int unsigned PA_W  = 48;
  parameter int unsigned OFS_W = 12;
  parameter int unsigned IDX_W = 9;
  parameter int unsigned LVLS  = 4;
  parameter int unsigned PTE_W = 64;
  localparam int unsigned FRAME_W = PA_W - OFS_W;
  localparam int unsigned LVL_W   = $clog2(LVLS);

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_MEM} walk_st_e;
endpackage

// File: rtl/pw_cache.sv
module pw_cache #(
  parameter int unsigned TAG_W   = 9,
  parameter int unsigned DATA_W  = 36,
  parameter int unsigned ENTRIES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              fill_i,
  input  logic [DATA_W-1:0] fill_data_i
);
  localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]             vld_q;
  logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
  logic [ENTRIES-1:0][DATA_W-1:0] data_q;
  logic [PTR_W-1:0]               ptr_q;
  logic [ENTRIES-1:0]             match;

  always_comb begin
    data_o = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      match[e] = vld_q[e] && (tag_q[e] == tag_i);
      if (match[e]) data_o = data_o | data_q[e];
    end
    hit_o = |match;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      tag_q  <= '0;
      data_q <= '0;
      ptr_q  <= '0;
    end else begin
      if (fill_i) begin
        vld_q[ptr_q]  <= 1'b1;
        tag_q[ptr_q]  <= tag_i;
        data_q[ptr_q] <= fill_data_i;
        ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
      if (flush_i) vld_q <= '0;
    end
  end
endmodule

// File: rtl/pw_pick.sv
module pw_pick
  import pw_pkg::*;
(
  input  logic [LVLS-1:0]              hit_i,
  input  logic [LVLS-1:0][FRAME_W-1:0] data_i,
  input  logic [FRAME_W-1:0]           root_i,
  output logic                         final_hit_o,
  output logic [LVL_W-1:0]             start_lvl_o,
  output logic [FRAME_W-1:0]           start_base_o
);
  // Ascending scan, so the deepest pointer hit overrides shallower ones
  always_comb begin
    final_hit_o  = hit_i[LVLS-1];
    start_lvl_o  = '0;
    start_base_o = root_i;
    for (int l = 0; l < LVLS - 1; l++) begin
      if (hit_i[l]) begin
        start_lvl_o  = LVL_W'(l + 1);
        start_base_o = data_i[l];
      end
    end
  end
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
#(
  parameter int unsigned ENTRIES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic [FRAME_W-1:0]  root_frame_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [VA_W-1:0]     req_vaddr_i,
  output logic                mem_req_o,
  output logic [PA_W-1:0]     mem_addr_o,
  input  logic                mem_rsp_valid_i,
  input  logic [PTE_W-1:0]    mem_rsp_data_i,
  output logic                done_o,
  output logic [FRAME_W-1:0]  pfn_o,
  output logic                fault_o
);
  walk_st_e            st_q;
  logic [VA_W-1:0]     va_q;
  logic [LVL_W-1:0]    lvl_q;
  logic [FRAME_W-1:0]  base_q;

  logic [LVLS-1:0]              hit;
  logic [LVLS-1:0][FRAME_W-1:0] hdata;
  logic [LVLS-1:0]              fill;
  logic                         final_hit;
  logic [LVL_W-1:0]             start_lvl;
  logic [FRAME_W-1:0]           start_base;
  logic [IDX_W-1:0]             cur_idx;
  logic                         rsp_ok, present;
  logic [FRAME_W-1:0]           nxt_frame;

  assign rsp_ok    = (st_q == ST_MEM) && mem_rsp_valid_i;
  assign present   = mem_rsp_data_i[0];
  assign nxt_frame = mem_rsp_data_i[PA_W-1:OFS_W];

  // Level 0..LVLS-2 are pointer caches, level LVLS-1 holds final frames
  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    localparam int unsigned TW = IDX_W * (l + 1);
    assign fill[l] = rsp_ok && present && (lvl_q == LVL_W'(l));
    pw_cache #(
      .TAG_W  (TW),
      .DATA_W (FRAME_W),
      .ENTRIES(ENTRIES)
    ) u_cache (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (flush_i),
      .tag_i      (va_q[VA_W-1 -: TW]),
      .hit_o      (hit[l]),
      .data_o     (hdata[l]),
      .fill_i     (fill[l]),
      .fill_data_i(nxt_frame)
    );
  end

  pw_pick u_pick (
    .hit_i       (hit),
    .data_i      (hdata),
    .root_i      (root_frame_i),
    .final_hit_o (final_hit),
    .start_lvl_o (start_lvl),
    .start_base_o(start_base)
  );

  always_comb begin
    cur_idx = va_q[VA_W-1 -: IDX_W];
    for (int l = 0; l < LVLS; l++)
      if (lvl_q == LVL_W'(l)) cur_idx = va_q[VA_W-1-IDX_W*l -: IDX_W];
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q == ST_MEM);
  assign mem_addr_o  = {base_q, {OFS_W{1'b0}}} + PA_W'({cur_idx, 3'b000});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      lvl_q   <= '0;
      base_q  <= '0;
      done_o  <= 1'b0;
      fault_o <= 1'b0;
      pfn_o   <= '0;
    end else begin
      done_o  <= 1'b0;
      fault_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q <= req_vaddr_i;
          st_q <= ST_LOOK;
        end
        ST_LOOK: if (final_hit) begin
          done_o <= 1'b1;
          pfn_o  <= hdata[LVLS-1];
          st_q   <= ST_IDLE;
        end else begin
          lvl_q  <= start_lvl;
          base_q <= start_base;
          st_q   <= ST_MEM;
        end
        ST_MEM: if (mem_rsp_valid_i) begin
          if (!present) begin
            done_o  <= 1'b1;
            fault_o <= 1'b1;
            pfn_o   <= '0;
            st_q    <= ST_IDLE;
          end else if (lvl_q == LVL_W'(LVLS - 1)) begin
            done_o <= 1'b1;
            pfn_o  <= nxt_frame;
            st_q   <= ST_IDLE;
          end else begin
            lvl_q  <= lvl_q + 1'b1;
            base_q <= nxt_frame;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pw_chk.sv
module pw_chk
  import pw_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic               mem_req_o,
  input logic [PA_W-1:0]    mem_addr_o,
  input logic               mem_rsp_valid_i,
  input logic               done_o,
  input logic [FRAME_W-1:0] pfn_o,
  input logic               fault_o
);
  // R13
  busy_no_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);
  // R13
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  // R13
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R1
  addr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[2:0] == 3'b000));
  // R1
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rsp_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R8
  fault_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (done_o && pfn_o == '0));
endmodule

bind page_walker pw_chk i_pw_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .mem_req_o      (mem_req_o),
  .mem_addr_o     (mem_addr_o),
  .mem_rsp_valid_i(mem_rsp_valid_i),
  .done_o         (done_o),
  .pfn_o          (pfn_o),
  .fault_o        (fault_o)
);

// File: tb/test_page_walker.sv
`timescale 1ns/1ps
module test_page_walker;
  import pw_pkg::*;

  logic clk = 1'b0, rst_ni = 1'b0, flush = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [VA_W-1:0] req_va = '0;
  logic mem_req, rsp_valid = 1'b0;
  logic [PA_W-1:0] mem_addr;
  logic [PTE_W-1:0] rsp_data = '0;
  logic done, fault;
  logic [FRAME_W-1:0] pfn;
  logic [FRAME_W-1:0] root = 36'h00100;

  int n_chk = 0, n_err = 0;
  int lat = 0, wcnt = 0, rd_cnt = 0;
  logic [PA_W-1:0] rd_addr [8];
  logic fault_on = 0, self_on = 0, alias_on = 0;
  logic [PA_W-1:0] fault_addr = '0, alias_a = '0, alias_b = '0;
  logic [FRAME_W-1:0] alias_frame = 36'h0ABCD;

  always #2 clk = ~clk;

  page_walker i_page_walker (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush), .root_frame_i(root),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_va),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rsp_valid_i(rsp_valid),
    .mem_rsp_data_i(rsp_data), .done_o(done), .pfn_o(pfn), .fault_o(fault));

  function automatic logic [PTE_W-1:0] mem_entry(input logic [PA_W-1:0] a);
    logic [44:0] h;
    if (fault_on && a == fault_addr) return '0;
    if (self_on && a == {root, 12'h000}) return {16'h0, root, 12'h001};
    if (alias_on && (a == alias_a || a == alias_b)) return {16'h0, alias_frame, 12'h001};
    h = a[47:3] * 45'd40503 + 45'h123457;
    return {16'h0, h[35:0], 12'h001};
  endfunction

  function automatic logic [PA_W-1:0] ent_addr(input logic [FRAME_W-1:0] f,
                                              input logic [VA_W-1:0] va, input int l);
    logic [IDX_W-1:0] idx = va[VA_W-1-IDX_W*l -: IDX_W];
    return {f, 12'h000} + PA_W'({idx, 3'b000});
  endfunction

  // fr[0] = root, fr[l+1] = frame read at level l, fr[4] = final frame
  function automatic void walk_ref(input logic [VA_W-1:0] va, output logic [4:0][FRAME_W-1:0] fr);
    fr[0] = root;
    for (int l = 0; l < 4; l++) begin
      logic [PTE_W-1:0] e = mem_entry(ent_addr(fr[l], va, l));
      fr[l+1] = e[47:12];
    end
  endfunction

  // Memory: answers lat cycles after a read appears, one beat per read
  always @(negedge clk) begin
    if (rsp_valid) begin
      rsp_valid <= 1'b0;
      wcnt <= 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        rsp_valid <= 1'b1;
        rsp_data  <= mem_entry(mem_addr);
        if (rd_cnt < 8) rd_addr[rd_cnt] <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end else wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic do_flush();
    @(negedge clk) flush = 1'b1;
    @(negedge clk) flush = 1'b0;
  endtask

  logic [FRAME_W-1:0] g_pfn;
  logic g_fault;
  int g_n;

  task automatic xlate(input logic [VA_W-1:0] va);
    @(negedge clk);
    rd_cnt = 0;
    req_va = va;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R13 busy after accept", req_ready, 1'b0);
    while (!done) @(negedge clk);
    g_pfn = pfn; g_fault = fault; g_n = rd_cnt;
    @(negedge clk);
    chk("R13 done pulse", done, 1'b0);
  endtask

  // s = level the walk must resume at (4 = final cache hit)
  task automatic do_case(input string rq, input logic [VA_W-1:0] va, input int s);
    logic [4:0][FRAME_W-1:0] fr;
    walk_ref(va, fr);
    xlate(va);
    chk(rq, 64'(g_n), 64'(4 - s));
    chk(rq, 64'(g_pfn), 64'(fr[4]));
    chk(rq, 64'(g_fault), 64'd0);
    if (s < 4) chk(rq, rd_addr[0], ent_addr(fr[s], va, s));
  endtask

  function automatic logic [VA_W-1:0] mk(input int a, input int b, input int c, input int d);
    return {9'(a), 9'(b), 9'(c), 9'(d), 12'h0};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R13 reset ready", req_ready, 1'b1);
    chk("R13 reset done", done, 1'b0);
    chk("R1 reset no read", mem_req, 1'b0);

    // R2 / R1: cold walks over top and last index, varying latency
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        logic [VA_W-1:0] va = mk(i * 85, 17 + i, 200 - j, j * 127);
        logic [4:0][FRAME_W-1:0] fr;
        lat = (i + j) % 3;
        do_flush();
        walk_ref(va, fr);
        do_case("R2 cold walk", va, 0);
        for (int l = 1; l < 4; l++) chk("R1 read address", rd_addr[l], ent_addr(fr[l], va, l));
      end
    end

    // R3..R7: warm cache, change one field at a time
    lat = 1;
    do_flush();
    do_case("R2 warm-up", mk(5, 6, 7, 8), 0);
    do_case("R3 final hit", mk(5, 6, 7, 8), 4);
    do_case("R3 same page offset", mk(5, 6, 7, 8) | 48'hABC, 4);
    do_case("R4 R7 third-level hit", mk(5, 6, 7, 9), 3);
    do_case("R5 second-level hit", mk(5, 6, 10, 9), 2);
    do_case("R6 top-level hit", mk(5, 11, 10, 9), 1);
    do_case("R2 new top index", mk(12, 11, 10, 9), 0);

    // R8: non-present root entry faults, no fill
    do_flush();
    fault_on = 1; fault_addr = {root, 12'h000} + 48'd72;
    for (int k = 0; k < 2; k++) begin
      xlate(mk(9, 1, 2, 3));
      chk("R8 fault flag", 64'(g_fault), 64'd1);
      chk("R8 fault pfn", 64'(g_pfn), 64'd0);
      chk("R8 one read, no fill", 64'(g_n), 64'd1);
    end
    fault_on = 0;

    // R9: self-referencing root entry
    do_flush();
    self_on = 1;
    do_case("R9 self walk", 48'h0, 0);
    chk("R9 self pfn", 64'(g_pfn), 64'(root));
    for (int l = 1; l < 4; l++) chk("R9 self read", rd_addr[l], {root, 12'h000});
    do_case("R9 third-level holds root", mk(0, 0, 0, 5), 3);
    do_case("R9 second-level holds root", mk(0, 0, 1, 0), 2);
    self_on = 0;

    // R10: two root entries share a table
    do_flush();
    alias_on = 1;
    alias_a = {root, 12'h000} + 48'd24;
    alias_b = {root, 12'h000} + 48'd56;
    begin
      logic [PA_W-1:0] p_rd1;
      logic [FRAME_W-1:0] p_pfn;
      do_case("R10 alias first", mk(3, 10, 20, 30), 0);
      p_rd1 = rd_addr[1]; p_pfn = g_pfn;
      do_case("R10 alias second", mk(7, 10, 20, 30), 0);
      chk("R10 shared table read", rd_addr[1], p_rd1);
      chk("R10 shared frame", 64'(g_pfn), 64'(p_pfn));
      do_case("R10 first tag kept", mk(3, 10, 20, 31), 3);
      do_case("R10 second tag kept", mk(7, 10, 20, 31), 3);
    end
    alias_on = 0;

    // R12: round-robin replacement in the final cache
    do_flush();
    do_case("R12 fill 0", mk(1, 2, 3, 0), 0);
    for (int k = 1; k < 5; k++) do_case("R12 fill", mk(1, 2, 3, k), 3);
    do_case("R12 oldest evicted", mk(1, 2, 3, 0), 3);
    do_case("R12 third kept", mk(1, 2, 3, 2), 4);
    do_case("R12 second evicted", mk(1, 2, 3, 1), 3);

    // R11: flush clears all levels
    do_flush();
    do_case("R11 after flush", mk(1, 2, 3, 2), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule